// File: doc/BRIEF.md
# Linked-Descriptor Page Table Refill Engine

This block loads physical page entries into a two-dimensional lookup table. Each table is addressed by a table ID, a row and a column. Software builds a chain of descriptors in memory. Each descriptor is four aligned 32-bit words. It names a rectangle of one table and points at an array of 32-bit entries. Software then writes the address of the first descriptor into the engine. The engine reads each descriptor, checks it, and copies one entry per table cell in row-major order. It then follows the link word to the next descriptor, and a link of zero ends the chain.

Progress is reported through four status flags: ready, valid, done and error. An eight-bit interrupt field marks completion of the final descriptor and two kinds of malformed descriptor. Separate enable-set and enable-clear writes decide which interrupt bits drive the interrupt line. The engine fetches from memory over a simple request/response read port with one read outstanding. The engine drives the table through a registered write port.

Top module: `refill_engine`

## Requirements
- R1: After reset the status is 4'b0001 (bit0 ready, bit1 valid, bit2 done, bit3 error). The interrupt status and the interrupt enable are zero, `irq_o` is low, and neither `mem_req` nor `tbl_we` is asserted.
- R2: `cfg_sel` encodes 0 = descriptor pointer, 1 = interrupt status clear, 2 = enable set, 3 = enable clear. A nonzero write to the descriptor pointer while ready is 1 starts a walk and clears ready, valid and done. A nonzero write while ready is 0 is ignored.
- R3: Writing zero to the descriptor pointer at any time stops the walk. No further table writes follow, and the status becomes 4'b0001 on the next cycle.
- R4: A descriptor at byte address P holds the link at P, the area at P+4 (x0 in bits [7:0], y0 in [15:8], x1 in [23:16], y1 in [31:24]), the control word at P+8 (bit0 start, table ID in bits [4+IDW-1:4]) and the entry array address at P+12.
- R5: A started descriptor produces exactly (x1-x0+1)*(y1-y0+1) table writes. They run in row-major order, x fastest. Write k carries the word read from array address + 4k and targets (table ID, x, y).
- R6: The engine follows the link word. After a descriptor whose link is zero, the status becomes 4'b0111.
- R7: A descriptor whose start bit is 0 produces no table writes, and the walk continues with its link.
- R8: If the start pointer, a link or an entry array address has any of its low four bits set, the engine sets error (status 4'b1000) and sets interrupt bit 1. The offending descriptor produces no table writes.
- R9: If an area has x1<x0, y1<y0, x1 at or above 2^XW, or y1 at or above 2^YW, the engine sets error (status 4'b1000) and sets interrupt bit 2, with no table writes from that descriptor.
- R10: Interrupt bit 4 (last) rises in the same cycle as the done flag, which is the cycle after the final table write.
- R11: An interrupt status bit stays set until a status-clear write with a one in that bit position. Enable-set writes OR into the enable and enable-clear writes remove bits. `irq_o` is high exactly when some status bit is set together with its enable bit.
- R12: Every memory read is a single-cycle `mem_req` pulse with one read outstanding. A successful walk issues four reads per descriptor plus one per table write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | AW | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tbl_we | output | 1 | Table write strobe |
| tbl_id | output | IDW | Table select |
| tbl_x | output | XW | Table column |
| tbl_y | output | YW | Table row |
| tbl_data | output | 32 | Table entry |
| stat_o | output | 4 | Status flags {error, done, valid, ready} |
| irq_stat_o | output | 8 | Interrupt status field |
| irq_en_o | output | 8 | Interrupt enable |
| irq_o | output | 1 | Interrupt line |

## Verification
A wrong cursor or a lost link shows at once on the table port: a cell is written out of row-major order, the write count per rectangle differs from the area product, or a cell holds an entry taken from the wrong array offset. If the sequencer stops or jumps to the wrong state, the done or error flag never arrives, or arrives without the matching interrupt bit in the same cycle. A stuck request shows up as a doubled `mem_req` or a read count that does not match the chain. An abort that leaves state behind shows up as table writes continuing after the zero write.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [2:0] {W_IDLE, W_DESC, W_CHECK, W_ENTRY, W_NEXT} walk_t;

  typedef enum logic [1:0] {
    SEL_DESC = 2'd0,
    SEL_ICLR = 2'd1,
    SEL_ESET = 2'd2,
    SEL_ECLR = 2'd3
  } sel_t;

  localparam int IRQ_PTR  = 1;
  localparam int IRQ_AREA = 2;
  localparam int IRQ_LAST = 4;
  localparam int IRQ_W    = 8;
  localparam int ALIGN_B  = 4;

  typedef struct packed {
    logic [7:0] y1;
    logic [7:0] x1;
    logic [7:0] y0;
    logic [7:0] x0;
  } area_t;
endpackage

// File: rtl/refill_rect.sv
module refill_rect #(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [XW-1:0] x0,
  input  logic [YW-1:0] y0,
  input  logic [XW-1:0] x1,
  input  logic [YW-1:0] y1,
  output logic [XW-1:0] cx,
  output logic [YW-1:0] cy,
  output logic          last
);
  logic [XW-1:0] xlo, xhi;
  logic [YW-1:0] yhi;

  always_ff @(posedge clk) begin
    if (rst) begin
      cx  <= '0;
      cy  <= '0;
      xlo <= '0;
      xhi <= '0;
      yhi <= '0;
    end else if (load) begin
      cx  <= x0;
      cy  <= y0;
      xlo <= x0;
      xhi <= x1;
      yhi <= y1;
    end else if (step) begin
      if (cx == xhi) begin
        cx <= xlo;
        cy <= cy + 1'b1;
      end else begin
        cx <= cx + 1'b1;
      end
    end
  end

  assign last = (cx == xhi) && (cy == yhi);
endmodule

// File: rtl/refill_walker.sv
module refill_walker
  import refill_pkg::*;
#(
  parameter int AW  = 32,
  parameter int XW  = 3,
  parameter int YW  = 3,
  parameter int IDW = 2,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           abort,
  input  logic [AW-1:0]  start_ptr,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  output logic           tbl_we,
  output logic [IDW-1:0] tbl_id,
  output logic [XW-1:0]  tbl_x,
  output logic [YW-1:0]  tbl_y,
  output logic [DW-1:0]  tbl_data,
  output logic [3:0]     status,
  output logic           ev_ptr,
  output logic           ev_area,
  output logic           ev_last
);
  localparam int TBL_W = 1 << XW;
  localparam int TBL_H = 1 << YW;

  walk_t         state;
  logic [1:0]    widx;
  logic [AW-1:0] ptr, nxt, dptr, eaddr;
  area_t         area;
  logic [DW-1:0] ctrl;
  logic          ready, valid, done, err;

  logic [XW-1:0] cx;
  logic [YW-1:0] cy;
  logic          rlast, rload, rstep;
  logic          start_ok, start_mis, in_chk, bad_ptr, bad_area, go;

  always_comb begin
    start_ok  = (state == W_IDLE) && start && ready && !abort;
    start_mis = start_ok && (start_ptr[ALIGN_B-1:0] != '0);
    in_chk    = (state == W_CHECK) && !abort;
    bad_ptr   = (nxt[ALIGN_B-1:0] != '0) || (dptr[ALIGN_B-1:0] != '0);
    bad_area  = (area.x1 < area.x0) || (area.y1 < area.y0) ||
                (int'(area.x1) >= TBL_W) || (int'(area.y1) >= TBL_H);
    ev_ptr    = start_mis || (in_chk && bad_ptr);
    ev_area   = in_chk && !bad_ptr && bad_area;
    go        = in_chk && !bad_ptr && !bad_area && ctrl[0];
    rload     = go;
    rstep     = (state == W_ENTRY) && !abort && mem_rvalid && !rlast;
    ev_last   = (state == W_NEXT) && !abort && (nxt == '0);
  end

  refill_rect #(.XW(XW), .YW(YW)) u_rect (
    .clk  (clk),
    .rst  (rst),
    .load (rload),
    .step (rstep),
    .x0   (area.x0[XW-1:0]),
    .y0   (area.y0[YW-1:0]),
    .x1   (area.x1[XW-1:0]),
    .y1   (area.y1[YW-1:0]),
    .cx   (cx),
    .cy   (cy),
    .last (rlast)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= W_IDLE;
      widx     <= '0;
      ptr      <= '0;
      nxt      <= '0;
      dptr     <= '0;
      eaddr    <= '0;
      area     <= '0;
      ctrl     <= '0;
      ready    <= 1'b1;
      valid    <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      tbl_we   <= 1'b0;
      tbl_id   <= '0;
      tbl_x    <= '0;
      tbl_y    <= '0;
      tbl_data <= '0;
    end else begin
      mem_req <= 1'b0;
      tbl_we  <= 1'b0;
      if (abort) begin
        state <= W_IDLE;
        ready <= 1'b1;
        valid <= 1'b0;
        done  <= 1'b0;
        err   <= 1'b0;
      end else begin
        case (state)
          W_IDLE: begin
            if (start_ok) begin
              ready <= 1'b0;
              valid <= 1'b0;
              done  <= 1'b0;
              if (start_mis) begin
                err <= 1'b1;
              end else begin
                ptr      <= start_ptr;
                widx     <= '0;
                mem_req  <= 1'b1;
                mem_addr <= start_ptr;
                state    <= W_DESC;
              end
            end
          end
          W_DESC: begin
            if (mem_rvalid) begin
              case (widx)
                2'd0:    nxt  <= mem_rdata;
                2'd1:    area <= mem_rdata;
                2'd2:    ctrl <= mem_rdata;
                default: dptr <= mem_rdata;
              endcase
              if (widx == 2'd3) begin
                state <= W_CHECK;
              end else begin
                widx     <= widx + 1'b1;
                mem_req  <= 1'b1;
                mem_addr <= ptr + AW'({widx + 1'b1, 2'b00});
              end
            end
          end
          W_CHECK: begin
            if (ev_ptr || ev_area) begin
              err   <= 1'b1;
              state <= W_IDLE;
            end else if (go) begin
              valid    <= 1'b1;
              eaddr    <= dptr;
              mem_req  <= 1'b1;
              mem_addr <= dptr;
              state    <= W_ENTRY;
            end else begin
              state <= W_NEXT;
            end
          end
          W_ENTRY: begin
            if (mem_rvalid) begin
              tbl_we   <= 1'b1;
              tbl_id   <= ctrl[4 +: IDW];
              tbl_x    <= cx;
              tbl_y    <= cy;
              tbl_data <= mem_rdata;
              if (rlast) begin
                state <= W_NEXT;
              end else begin
                eaddr    <= eaddr + AW'(4);
                mem_req  <= 1'b1;
                mem_addr <= eaddr + AW'(4);
              end
            end
          end
          W_NEXT: begin
            if (ev_last) begin
              done  <= 1'b1;
              ready <= 1'b1;
              state <= W_IDLE;
            end else begin
              ptr      <= nxt;
              widx     <= '0;
              mem_req  <= 1'b1;
              mem_addr <= nxt;
              state    <= W_DESC;
            end
          end
          default: state <= W_IDLE;
        endcase
      end
    end
  end

  assign status = {err, done, valid, ready};
endmodule

// File: rtl/refill_irq.sv
module refill_irq #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_vec,
  input  logic [NB-1:0] clr_vec,
  input  logic [NB-1:0] en_set,
  input  logic [NB-1:0] en_clr,
  output logic [NB-1:0] stat,
  output logic [NB-1:0] en,
  output logic          irq
);
  logic [NB-1:0] st_nx, en_nx;

  for (genvar i = 0; i < NB; i++) begin : g_bit
    assign st_nx[i] = set_vec[i] | (stat[i] & ~clr_vec[i]);
    assign en_nx[i] = (en[i] | en_set[i]) & ~en_clr[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      en   <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= st_nx;
      en   <= en_nx;
      irq  <= |(st_nx & en_nx);
    end
  end
endmodule

// File: rtl/refill_engine.sv
module refill_engine
  import refill_pkg::*;
#(
  parameter int AW  = 32,
  parameter int XW  = 3,
  parameter int YW  = 3,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_rvalid,
  input  logic [31:0]    mem_rdata,
  output logic           tbl_we,
  output logic [IDW-1:0] tbl_id,
  output logic [XW-1:0]  tbl_x,
  output logic [YW-1:0]  tbl_y,
  output logic [31:0]    tbl_data,
  output logic [3:0]     stat_o,
  output logic [7:0]     irq_stat_o,
  output logic [7:0]     irq_en_o,
  output logic           irq_o
);
  logic              wr_desc, start, abort;
  logic              ev_ptr, ev_area, ev_last;
  logic [IRQ_W-1:0]  set_vec, clr_vec, en_set, en_clr;

  always_comb begin
    wr_desc = cfg_wr && (cfg_sel == SEL_DESC);
    start   = wr_desc && (cfg_wdata != '0);
    abort   = wr_desc && (cfg_wdata == '0);
    set_vec = '0;
    set_vec[IRQ_PTR]  = ev_ptr;
    set_vec[IRQ_AREA] = ev_area;
    set_vec[IRQ_LAST] = ev_last;
    clr_vec = (cfg_wr && cfg_sel == SEL_ICLR) ? cfg_wdata[IRQ_W-1:0] : '0;
    en_set  = (cfg_wr && cfg_sel == SEL_ESET) ? cfg_wdata[IRQ_W-1:0] : '0;
    en_clr  = (cfg_wr && cfg_sel == SEL_ECLR) ? cfg_wdata[IRQ_W-1:0] : '0;
  end

  refill_walker #(.AW(AW), .XW(XW), .YW(YW), .IDW(IDW), .DW(32)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .abort      (abort),
    .start_ptr  (cfg_wdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .tbl_we     (tbl_we),
    .tbl_id     (tbl_id),
    .tbl_x      (tbl_x),
    .tbl_y      (tbl_y),
    .tbl_data   (tbl_data),
    .status     (stat_o),
    .ev_ptr     (ev_ptr),
    .ev_area    (ev_area),
    .ev_last    (ev_last)
  );

  refill_irq #(.NB(IRQ_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .en_set  (en_set),
    .en_clr  (en_clr),
    .stat    (irq_stat_o),
    .en      (irq_en_o),
    .irq     (irq_o)
  );
endmodule

// File: rtl/refill_engine_chk.sv
module refill_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_wr,
  input logic [1:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic          mem_req,
  input logic          tbl_we,
  input logic [3:0]    stat_o,
  input logic [7:0]    irq_stat_o,
  input logic [7:0]    irq_en_o,
  input logic          irq_o
);
  a_r3_zero_gives_ready: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_sel == 2'd0 && cfg_wdata == '0) |=> (stat_o == 4'b0001));

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  a_r5_write_needs_valid: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> stat_o[1]);

  a_r8_error_excludes_done: assert property (@(posedge clk) disable iff (rst)
    stat_o[3] |-> (!stat_o[2] && !stat_o[0]));

  a_r10_last_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_o[2]) |-> irq_stat_o[4]);

  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (irq_en_o == 8'h00) |-> !irq_o);
endmodule

bind refill_engine refill_engine_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .cfg_sel    (cfg_sel),
  .cfg_wdata  (cfg_wdata),
  .mem_req    (mem_req),
  .tbl_we     (tbl_we),
  .stat_o     (stat_o),
  .irq_stat_o (irq_stat_o),
  .irq_en_o   (irq_en_o),
  .irq_o      (irq_o)
);

// File: tb/tb_refill_engine.sv
module tb_refill_engine;
  localparam int CLK_T = 10;
  localparam int AW = 32, XW = 3, YW = 3, IDW = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cfg_wr = 1'b0;
  logic [1:0]     cfg_sel = 2'd0;
  logic [AW-1:0]  cfg_wdata = '0;
  logic           mem_req;
  logic [AW-1:0]  mem_addr;
  logic           mem_rvalid = 1'b0;
  logic [31:0]    mem_rdata = '0;
  logic           tbl_we;
  logic [IDW-1:0] tbl_id;
  logic [XW-1:0]  tbl_x;
  logic [YW-1:0]  tbl_y;
  logic [31:0]    tbl_data;
  logic [3:0]     stat_o;
  logic [7:0]     irq_stat_o, irq_en_o;
  logic           irq_o;

  refill_engine #(.AW(AW), .XW(XW), .YW(YW), .IDW(IDW)) dut (.*);

  always #(CLK_T/2) clk = ~clk;

  logic [31:0] mem [256];
  logic [31:0] shadow [4][8][8];
  int n_chk = 0, n_bad = 0;
  int wcnt, reqcnt, lst_at, w3x, w3y;
  bit lst_seen;

  // chains: start, writes, status, irq status
  localparam logic [31:0] VEC [6][4] = '{
    '{32'h040, 32'd8, 32'h7, 32'h10},
    '{32'h104, 32'd0, 32'h8, 32'h02},
    '{32'h100, 32'd0, 32'h8, 32'h04},
    '{32'h140, 32'd4, 32'h7, 32'h10},
    '{32'h1C0, 32'd0, 32'h8, 32'h02},
    '{32'h1E0, 32'd0, 32'h8, 32'h04}
  };

  always @(posedge clk) begin
    mem_rvalid <= rst ? 1'b0 : mem_req;
    mem_rdata  <= mem[mem_addr[9:2]];
  end

  always @(posedge clk) begin
    #1;
    if (mem_req) reqcnt++;
    if (tbl_we) begin
      shadow[tbl_id][tbl_y][tbl_x] = tbl_data;
      wcnt++;
      if (wcnt == 3) begin w3x = int'(tbl_x); w3y = int'(tbl_y); end
    end
    if (irq_stat_o[4] && !lst_seen) begin lst_seen = 1; lst_at = wcnt; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic clr_mon();
    wcnt = 0; reqcnt = 0; lst_seen = 0; lst_at = -1; w3x = -1; w3y = -1;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 8; c++) shadow[a][b][c] = '0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(stat_o[0] || stat_o[3]) && n < 2000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    if (n >= 2000) begin n_chk++; n_bad++; $display("FAIL R6 walk never ended actual=busy expected=ended"); end
  endtask

  task automatic run(input logic [31:0] p);
    cfg(2'd0, 32'h0);
    cfg(2'd1, 32'hFF);
    clr_mon();
    cfg(2'd0, p);
    wait_end();
  endtask

  task automatic put(input int wi, input logic [31:0] nx, ar, ct, dp);
    mem[wi] = nx; mem[wi+1] = ar; mem[wi+2] = ct; mem[wi+3] = dp;
  endtask

  initial begin
    #(CLK_T * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int wsave;
    for (int i = 0; i < 256; i++) mem[i] = (i >= 128 && i < 192) ? 32'hD000_0000 + i : 32'h0;
    put(16,  32'h080, 32'h0102_0001, 32'h11, 32'h200);
    put(32,  32'h0C0, 32'h0303_0303, 32'h21, 32'h240);
    put(48,  32'h000, 32'h0202_0200, 32'h01, 32'h280);
    put(64,  32'h000, 32'h0001_0002, 32'h01, 32'h200);
    put(80,  32'h180, 32'h0000_0000, 32'h00, 32'h200);
    put(96,  32'h000, 32'h0101_0000, 32'h31, 32'h2C0);
    put(112, 32'h1C4, 32'h0000_0000, 32'h01, 32'h200);
    put(120, 32'h000, 32'h0008_0000, 32'h01, 32'h200);
    clr_mon();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", 32'(stat_o), 32'h1);
    chk("R1 irq status", 32'(irq_stat_o), 32'h0);
    chk("R1 enable", 32'(irq_en_o), 32'h0);
    chk("R1 irq line/req/we", {29'b0, irq_o, mem_req, tbl_we}, 32'h0);
    // R11 enable set
    cfg(2'd2, 32'h7E);
    chk("R11 enable set", 32'(irq_en_o), 32'h7E);

    // vector walk: R5 R6 R7 R8 R9 R10
    for (int v = 0; v < 6; v++) begin
      run(VEC[v][0]);
      chk($sformatf("R6/R8/R9 status chain %0d", v), 32'(stat_o), VEC[v][2]);
      chk($sformatf("R5/R7 writes chain %0d", v), 32'(wcnt), VEC[v][1]);
      chk($sformatf("R8/R9/R10 irq status chain %0d", v), 32'(irq_stat_o), VEC[v][3]);
    end

    // chain A in detail: R4 R5 R10 R12 R11
    run(32'h040);
    chk("R4 cell id1 (1,0)", shadow[1][0][1], 32'hD000_0080);
    chk("R5 cell id1 (2,1)", shadow[1][1][2], 32'hD000_0083);
    chk("R5 cell id2 (3,3)", shadow[2][3][3], 32'hD000_0090);
    chk("R5 cell id0 (0,2)", shadow[0][2][0], 32'hD000_00A0);
    chk("R5 cell id0 (2,2)", shadow[0][2][2], 32'hD000_00A2);
    chk("R5 row-major third write", 32'(w3x * 16 + w3y), 32'h11);
    chk("R10 last bit after final write", 32'(lst_at), 32'd8);
    chk("R12 read count", 32'(reqcnt), 32'd20);
    chk("R11 irq high", 32'(irq_o), 32'h1);
    cfg(2'd3, 32'h10);
    chk("R11 masked irq low", 32'(irq_o), 32'h0);
    chk("R11 status kept", 32'(irq_stat_o), 32'h10);
    cfg(2'd2, 32'h10);
    chk("R11 re-enabled irq", 32'(irq_o), 32'h1);
    cfg(2'd1, 32'h10);
    chk("R11 w1c status", 32'(irq_stat_o), 32'h0);
    chk("R11 irq after clear", 32'(irq_o), 32'h0);

    // R7 skip descriptor then id3 rectangle
    run(32'h140);
    chk("R7 id3 (0,0)", shadow[3][0][0], 32'hD000_00B0);
    chk("R7 id3 (1,1)", shadow[3][1][1], 32'hD000_00B3);

    // R2 busy write ignored
    cfg(2'd0, 32'h0);
    cfg(2'd1, 32'hFF);
    clr_mon();
    cfg(2'd0, 32'h040);
    cfg(2'd0, 32'h100);
    wait_end();
    chk("R2 busy start ignored status", 32'(stat_o), 32'h7);
    chk("R2 busy start ignored writes", 32'(wcnt), 32'd8);

    // R3 abort mid-walk
    cfg(2'd0, 32'h0);
    clr_mon();
    cfg(2'd0, 32'h040);
    while (wcnt < 2) @(negedge clk);
    cfg(2'd0, 32'h0);
    chk("R3 abort status", 32'(stat_o), 32'h1);
    wsave = wcnt;
    repeat (40) @(negedge clk);
    chk("R3 no writes after abort", 32'(wcnt), 32'(wsave));
    chk("R3 stays ready", 32'(stat_o), 32'h1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule